// File: doc/BRIEF.md
# Two-Level Lookahead Adder

This block adds two 16-bit operands and a carry-in in one combinational pass. It returns a 16-bit sum and a carry-out. The operand bits are split into four slices of four bits each. Every slice forms a generate term and a propagate term for each bit. It then finds its internal carries with flat lookahead equations, and it also reports one propagate term and one generate term for the slice as a whole.

A second lookahead stage takes the slice-level terms and the carry-in. From them it forms the carries into slices 1, 2 and 3 and the final carry-out, all together. No carry ripples from one slice into the next, so the carry-out depth stays the same no matter where a carry is generated.

The block has no clock and no state. It is meant to sit inside a datapath wherever a short, fixed carry path is needed.

Top module: `cla_adder16`

## Requirements
- R1: For every input combination, {c16_o, sum_o} equals a_i + b_i + c0_i, taken as an unsigned 17-bit value.
- R2: The carry-in c0_i adds exactly one to the result. With a_i = b_i = 0 and c0_i = 1, sum_o is 0x0001 and c16_o is 0. With a_i = 0xFFFF, b_i = 0 and c0_i = 1, sum_o is 0x0000 and c16_o is 1.
- R3: When a slice produces a carry by itself (a bit with ai AND bi set, and propagate set on every higher bit of that slice), the next slice receives a carry even if the first slice had no carry in. Example: 0x0008 + 0x0008 = 0x0010.
- R4: A slice whose every bit has ai OR bi set passes its incoming carry on to the next slice. A slice with neither its propagate term nor its generate term set sends no carry. Example: 0x00FF + 0x0001 = 0x0100.
- R5: c16_o is 1 exactly when the true sum is at least 2^16. Example: 0x8000 + 0x8000 gives sum_o = 0x0000 and c16_o = 1.
- R6: The carry into slice k (k = 1..4, where slice 4 means c16_o) equals the carry out of bits 4k-1..0 plus c0_i. Slice k holds bits 4k+3..4k.
- R7: The outputs depend only on the present inputs. A new input value is reflected in the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| c0_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| c16_o | output | 1 | Carry out of bit 15 |

## Verification
The two functions that can act at the same moment are a carry generated inside a low slice and a run of propagating slices above it. A correct design hands that carry through every propagating slice to c16_o in the same evaluation. The bench provokes this with directed operands that generate in slice 0 while slices 1 to 3 only propagate. It also draws random operand pairs in which b_i is often close to the bitwise inverse of a_i, which produces long propagate runs. Every result is judged against a bit-serial ripple model and against plain integer addition.

// File: rtl/cla_pkg.sv
// Shared sizing for the two-level lookahead adder.
// Assumes slices of at least two bits.
package cla_pkg;
    localparam int SLICE_W_DEF  = 4;
    localparam int NUM_SLICE_DEF = 4;
endpackage

// File: rtl/cla_lookahead.sv
// Flat lookahead carry unit: from N propagate/generate pairs and a carry-in it
// forms carries into positions 1..N as two-level sum-of-products terms, with no
// ripple between positions. The same unit serves inside a slice and between slices.
module cla_lookahead #(
    parameter int N = 4
) (
    input  logic [N-1:0] prop_i,
    input  logic [N-1:0] gen_i,
    input  logic         cin_i,
    output logic [N:1]   carry_o
);
    // Expand each carry into an OR of AND products.
    always_comb begin
        for (int j = 0; j < N; j++) begin
            logic acc;
            logic prod;
            acc = cin_i;
            for (int m = 0; m <= j; m++) acc = acc & prop_i[m];
            for (int k = 0; k <= j; k++) begin
                prod = gen_i[k];
                for (int m = k + 1; m <= j; m++) prod = prod & prop_i[m];
                acc = acc | prod;
            end
            carry_o[j+1] = acc;
        end
    end
endmodule

// File: rtl/cla_slice.sv
// One slice of W bits: forms per-bit generate (a AND b) and inclusive-OR
// propagate, finds its internal carries by lookahead, and outputs sum bits
// plus slice-level propagate and generate. Carry-in comes from the upper level.
module cla_slice #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         grp_prop_o,
    output logic         grp_gen_o
);
    logic [W-1:0] bit_p;
    logic [W-1:0] bit_g;
    logic [W-1:0] half;
    logic [W-1:1] in_carry;
    logic [W-1:0] carry_vec;

    // Per-bit terms.
    always_comb begin
        bit_g = a_i & b_i;
        bit_p = a_i | b_i;
        half  = a_i ^ b_i;
    end

    cla_lookahead #(.N(W - 1)) la_i (
        .prop_i  (bit_p[W-2:0]),
        .gen_i   (bit_g[W-2:0]),
        .cin_i   (cin_i),
        .carry_o (in_carry)
    );

    // Sum bits from half-sum and carry into each bit.
    always_comb begin
        carry_vec = {in_carry, cin_i};
        sum_o     = half ^ carry_vec;
    end

    // Slice propagate and generate, flat form.
    always_comb begin
        logic prod;
        grp_prop_o = &bit_p;
        grp_gen_o  = 1'b0;
        for (int k = 0; k < W; k++) begin
            prod = bit_g[k];
            for (int m = k + 1; m < W; m++) prod = prod & bit_p[m];
            grp_gen_o = grp_gen_o | prod;
        end
    end
endmodule

// File: rtl/cla_adder16.sv
// Top of the two-level lookahead adder. Purely combinational: slices export
// propagate/generate, a second lookahead unit forms all slice carry-ins and
// the carry-out together. No clock or reset is needed.
module cla_adder16 #(
    parameter int SLICE_W   = cla_pkg::SLICE_W_DEF,
    parameter int NUM_SLICE = cla_pkg::NUM_SLICE_DEF
) (
    input  logic [SLICE_W*NUM_SLICE-1:0] a_i,
    input  logic [SLICE_W*NUM_SLICE-1:0] b_i,
    input  logic                         c0_i,
    output logic [SLICE_W*NUM_SLICE-1:0] sum_o,
    output logic                         c16_o
);
    localparam int WIDTH = SLICE_W * NUM_SLICE;

    logic [NUM_SLICE-1:0] slice_p;
    logic [NUM_SLICE-1:0] slice_g;
    logic [NUM_SLICE:1]   upper_carry;
    logic [NUM_SLICE:0]   slice_cin;

    cla_lookahead #(.N(NUM_SLICE)) top_la_i (
        .prop_i  (slice_p),
        .gen_i   (slice_g),
        .cin_i   (c0_i),
        .carry_o (upper_carry)
    );

    // Collect slice carry-ins: c0 for slice 0, upper unit for the rest.
    always_comb slice_cin = {upper_carry, c0_i};

    for (genvar s = 0; s < NUM_SLICE; s++) begin : g_slice
        cla_slice #(.W(SLICE_W)) slice_i (
            .a_i        (a_i[s*SLICE_W +: SLICE_W]),
            .b_i        (b_i[s*SLICE_W +: SLICE_W]),
            .cin_i      (slice_cin[s]),
            .sum_o      (sum_o[s*SLICE_W +: SLICE_W]),
            .grp_prop_o (slice_p[s]),
            .grp_gen_o  (slice_g[s])
        );
    end

    // Final carry-out from the upper unit.
    always_comb c16_o = slice_cin[NUM_SLICE];

    if (WIDTH < 2) begin : g_bad_width
        initial $error("cla_adder16: width too small");
    end
endmodule

// File: rtl/cla_adder16_chk.sv
// Checker bound to cla_adder16: relates the ports to integer addition and the
// slice terms to the upper-level carries. Combinational, so immediate checks.
module cla_adder16_chk #(
    parameter int SLICE_W   = 4,
    parameter int NUM_SLICE = 4
) (
    input logic [SLICE_W*NUM_SLICE-1:0] a_i,
    input logic [SLICE_W*NUM_SLICE-1:0] b_i,
    input logic                         c0_i,
    input logic [SLICE_W*NUM_SLICE-1:0] sum_o,
    input logic                         c16_o,
    input logic [NUM_SLICE-1:0]         slice_p,
    input logic [NUM_SLICE-1:0]         slice_g,
    input logic [NUM_SLICE:0]           slice_cin
);
    localparam int WIDTH = SLICE_W * NUM_SLICE;

    // Port result against integer addition.
    always_comb begin
        assert_sum_R1: assert ({c16_o, sum_o} ==
                               ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, c0_i}))
            else $error("R1 sum mismatch");
    end

    // Slice-level carry relations.
    always_comb begin
        logic [WIDTH:0] mask;
        logic [WIDTH:0] part;
        for (int k = 0; k < NUM_SLICE; k++) begin
            assert_gen_R3: assert (!slice_g[k] || slice_cin[k+1])
                else $error("R3 generate lost");
            assert_prop_R4: assert (!(slice_p[k] && slice_cin[k]) || slice_cin[k+1])
                else $error("R4 propagate lost");
            assert_kill_R4: assert (slice_p[k] || slice_g[k] || !slice_cin[k+1])
                else $error("R4 spurious carry");
        end
        for (int k = 1; k <= NUM_SLICE; k++) begin
            mask = ({{WIDTH{1'b0}}, 1'b1} << (k * SLICE_W)) - 1'b1;
            part = ({1'b0, a_i} & mask) + ({1'b0, b_i} & mask)
                 + {{WIDTH{1'b0}}, c0_i};
            assert_upper_R6: assert (slice_cin[k] == part[k*SLICE_W])
                else $error("R6 upper carry mismatch");
        end
    end
endmodule

bind cla_adder16 cla_adder16_chk #(
    .SLICE_W   (SLICE_W),
    .NUM_SLICE (NUM_SLICE)
) chk_i (
    .a_i       (a_i),
    .b_i       (b_i),
    .c0_i      (c0_i),
    .sum_o     (sum_o),
    .c16_o     (c16_o),
    .slice_p   (slice_p),
    .slice_g   (slice_g),
    .slice_cin (slice_cin)
);

// File: tb/cla_adder16_tb_top.sv
// Bench for cla_adder16: directed corners plus seeded random operands, each
// compared with a ripple model and with integer addition.
module cla_adder16_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a_s = '0;
    logic [15:0] b_s = '0;
    logic        c_s = 1'b0;
    logic [15:0] sum_w;
    logic        c16_w;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    cla_adder16 dut_i (
        .a_i   (a_s),
        .b_i   (b_s),
        .c0_i  (c_s),
        .sum_o (sum_w),
        .c16_o (c16_w)
    );

    // Bit-serial ripple reference.
    function automatic logic [16:0] ripple(input logic [15:0] a,
                                           input logic [15:0] b,
                                           input logic c);
        logic [15:0] s;
        logic cy;
        cy = c;
        for (int i = 0; i < 16; i++) begin
            s[i] = a[i] ^ b[i] ^ cy;
            cy   = (a[i] & b[i]) | (a[i] & cy) | (b[i] & cy);
        end
        return {cy, s};
    endfunction

    // Drive at falling edge, sample shortly after.
    task automatic apply(input logic [15:0] a, input logic [15:0] b,
                         input logic c, input string req);
        logic [16:0] exp_v;
        @(negedge clk);
        a_s = a; b_s = b; c_s = c;
        #1;
        exp_v = ripple(a, b, c);
        n_cmp++;
        if ({c16_w, sum_w} !== exp_v ||
            exp_v !== ({1'b0, a} + {1'b0, b} + {16'd0, c})) begin
            n_bad++;
            $display("FAIL %s a=%h b=%h c=%b actual=%h expected=%h",
                     req, a, b, c, {c16_w, sum_w}, exp_v);
        end
    endtask

    initial begin
        logic [15:0] ra;
        logic [15:0] rb;
        void'($urandom(32'h5A17));
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        apply(16'h0000, 16'h0000, 1'b0, "R1 reset/zero");
        apply(16'h0000, 16'h0000, 1'b1, "R2 carry-in only");
        apply(16'hFFFF, 16'h0000, 1'b1, "R2 all ones plus carry-in");
        apply(16'hFFFF, 16'hFFFF, 1'b1, "R5 max operands");
        apply(16'h0008, 16'h0008, 1'b0, "R3 slice generate");
        apply(16'h0800, 16'h0800, 1'b0, "R3 generate slice2");
        apply(16'h00FF, 16'h0001, 1'b0, "R4 propagate slice1");
        apply(16'hFFF0, 16'h000F, 1'b1, "R4 propagate chain to c16");
        apply(16'hFFF8, 16'h0008, 1'b0, "R6 generate through propagates");
        apply(16'h8000, 16'h8000, 1'b0, "R5 top bit carry");
        apply(16'hAAAA, 16'h5555, 1'b0, "R1 alternating");
        apply(16'hAAAA, 16'h5555, 1'b1, "R6 alternating with carry-in");
        apply(16'hAAAA, 16'hAAAA, 1'b1, "R1 same alternating");
        apply(16'h0F0F, 16'h00F1, 1'b0, "R6 mixed slices");
        apply(16'h1234, 16'h0000, 1'b0, "R7 first value");
        apply(16'h1234, 16'h4321, 1'b0, "R7 b change only");
        for (int i = 0; i < 400; i++) begin
            ra = 16'($urandom);
            case ($urandom % 3)
                0: rb = ~ra;
                1: rb = ~ra ^ (16'h1 << ($urandom % 16));
                default: rb = 16'($urandom);
            endcase
            apply(ra, rb, 1'($urandom), "R1 random");
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule